// File: doc/BRIEF.md
# Programmable Periodic Interrupt Divider

This block turns an oscillator strobe into two timing events for a real-time clock: a programmable periodic-flag set pulse and a one-second tick for the time-of-day counter. A 3-bit time-base selector picks how the strobe is scaled down to a 32768 Hz internal reference. The fast bases use a prescaler to reach that rate, the direct base uses the strobe as it is, and two codes clear the divider chain and hold it. The reference then clocks a 15-stage binary divider chain.

A 4-bit rate selector picks one octave of that chain as the periodic source, or none. Every rising edge of the selected octave produces a one-cycle set pulse for a downstream flag register. The last stage of the chain gives the one-second tick. Masking, flag storage and register access belong to neighbouring logic.

Top module: `periodic_rate_divider`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it is released, pf_set_o and sec_tick_o are low.
- R2: A reference tick comes from osc_en_i strobes as follows. With base_sel_i = 2, every strobe is a tick. With base_sel_i = 0, every 128th strobe is a tick. With base_sel_i = 1, every 32nd strobe is a tick. The strobe count starts from zero when the chain leaves hold, or when the base was 2.
- R3: base_sel_i of 6 or 7 clears the prescaler and the chain and keeps both outputs low. After leaving this hold, the first one-second tick comes on exactly the 32768th reference tick.
- R4: base_sel_i of 3, 4 or 5 freezes the prescaler and the chain at their current values and keeps both outputs low. Counting resumes from the frozen values.
- R5: rate_sel_i = 0 produces no periodic pulse.
- R6: For rate_sel_i = c in 3..15, the period is P = 2^(c-1) reference ticks (8192 Hz down to 2 Hz). Number the reference ticks k = 1, 2, ... from the last clear. A pulse comes on tick k when k mod P = P/2.
- R7: With base_sel_i = 2, rate codes 1 and 2 use P = 128 and P = 256 (256 Hz and 128 Hz). With bases 0 and 1, they use P = 1 (every tick) and P = 2, and the R6 rule applies.
- R8: sec_tick_o pulses for one cycle on every reference tick k where k mod 32768 = 0.
- R9: Both outputs are registered. They are high only in the cycle after a cycle that had a reference tick, so a cycle with osc_en_i low is followed by low outputs.
- R10: A change of rate_sel_i takes effect at the next rising edge of the newly selected octave. The pulses always follow the R6 and R7 rule for the current code, with no extra or shortened pulse at the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| osc_en_i | input | 1 | Oscillator strobe, one cycle per oscillator period |
| base_sel_i | input | 3 | Time-base selector: 0 = /128, 1 = /32, 2 = direct, 3..5 = freeze, 6..7 = hold cleared |
| rate_sel_i | input | 4 | Periodic rate selector, 0 = off |
| pf_set_o | output | 1 | One-cycle periodic-flag set pulse |
| sec_tick_o | output | 1 | One-cycle one-second tick |

## Verification
A wrong chain count shows as a shifted periodic pulse within one period of the selected octave: one reference tick at the fastest rate. The same fault shows as a misplaced one-second tick within 32768 reference ticks. A prescaler that wraps at the wrong count stretches or shortens every period on the fast bases from the first divided tick. A bad rate-to-stage mapping changes the pulse spacing the first time that code is selected. The bench compares both outputs every cycle against an arithmetic model of tick numbers, so it reports any such error in the cycle where it first appears.

// File: rtl/prd_pkg.sv
package prd_pkg;

  typedef enum logic [2:0] {
    MODE_DIV_HI,   // fast base, large prescale
    MODE_DIV_LO,   // fast base, small prescale
    MODE_DIRECT,   // strobe already at reference rate
    MODE_FREEZE,   // undefined bases: hold state
    MODE_CLEAR     // chain held in reset
  } base_mode_e;

  function automatic base_mode_e decode_base(input logic [2:0] code);
    case (code)
      3'd0:          return MODE_DIV_HI;
      3'd1:          return MODE_DIV_LO;
      3'd2:          return MODE_DIRECT;
      3'd6, 3'd7:    return MODE_CLEAR;
      default:       return MODE_FREEZE;
    endcase
  endfunction

  // stage n: tap period is 2^n reference ticks
  function automatic logic [3:0] rate_stage(input logic [3:0] rate, input logic direct);
    if (rate == 4'd1 || rate == 4'd2)
      return direct ? rate + 4'd6 : rate - 4'd1;
    else if (rate == 4'd0)
      return 4'd0;
    else
      return rate - 4'd1;
  endfunction

endpackage

// File: rtl/prd_prescaler.sv
module prd_prescaler
  import prd_pkg::*;
#(
  parameter int HI_DIV = 128,
  parameter int LO_DIV = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       osc_en_i,
  input  base_mode_e mode_i,
  output logic       ref_tick_o
);
  localparam int MAX_DIV = (HI_DIV > LO_DIV) ? HI_DIV : LO_DIV;
  localparam int CNT_W   = $clog2(MAX_DIV);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;
  logic             fast;
  logic             wrap;

  assign fast  = (mode_i == MODE_DIV_HI) || (mode_i == MODE_DIV_LO);
  assign limit = (mode_i == MODE_DIV_HI) ? CNT_W'(HI_DIV - 1) : CNT_W'(LO_DIV - 1);
  assign wrap  = (cnt_q >= limit);

  assign ref_tick_o = osc_en_i && ((mode_i == MODE_DIRECT) || (fast && wrap));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (mode_i == MODE_CLEAR || mode_i == MODE_DIRECT) begin
      cnt_q <= '0;
    end else if (fast && osc_en_i) begin
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end
  end

  // R2: a divided base never yields ticks on consecutive cycles
  a_r2_divided_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_tick_o && fast) |=> !(ref_tick_o && fast));

  // R4: frozen base makes no reference ticks
  a_r4_freeze_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_FREEZE) |-> !ref_tick_o);

endmodule

// File: rtl/prd_chain.sv
module prd_chain #(
  parameter int CHAIN_W = 15
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               clr_i,
  output logic [CHAIN_W-1:0] cnt_o,
  output logic               sec_o
);
  logic [CHAIN_W-1:0] cnt_q;

  assign cnt_o = cnt_q;
  assign sec_o = tick_i && (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  // R3: hold leaves the chain at zero
  a_r3_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_o == '0));

  // R8: second tick coincides with chain wrap
  a_r8_wrap_after_sec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_o && !clr_i) |=> (cnt_o == '0));

  // R4: chain moves only on a tick or clear
  a_r4_chain_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i) |=> $stable(cnt_o));

endmodule

// File: rtl/prd_tap_sel.sv
module prd_tap_sel #(
  parameter int CHAIN_W = 15,
  parameter int STG_W   = 4
) (
  input  logic [CHAIN_W-1:0] cnt_i,
  input  logic               tick_i,
  input  logic               en_i,
  input  logic [STG_W-1:0]   stage_i,
  output logic               hit_o
);
  logic [CHAIN_W-1:0] nxt;
  logic [CHAIN_W-1:0] rise;

  assign nxt     = cnt_i + 1'b1;
  assign rise[0] = 1'b1;

  // rise[j]: bit j-1 goes 0->1 on this tick, i.e. a 2^j-period edge
  for (genvar j = 1; j < CHAIN_W; j++) begin : g_rise
    assign rise[j] = ~cnt_i[j-1] & nxt[j-1];
  end

  assign hit_o = tick_i && en_i && (int'(stage_i) < CHAIN_W) && rise[stage_i];

endmodule

// File: rtl/periodic_rate_divider.sv
module periodic_rate_divider
  import prd_pkg::*;
#(
  parameter int HI_DIV  = 128,
  parameter int LO_DIV  = 32,
  parameter int CHAIN_W = 15
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       osc_en_i,
  input  logic [2:0] base_sel_i,
  input  logic [3:0] rate_sel_i,
  output logic       pf_set_o,
  output logic       sec_tick_o
);
  localparam int STG_W = 4;

  base_mode_e         mode;
  logic               ref_tick;
  logic [CHAIN_W-1:0] chain_cnt;
  logic               sec_hit;
  logic               pf_hit;
  logic [STG_W-1:0]   stage;
  logic               pf_q, sec_q;

  assign mode  = decode_base(base_sel_i);
  assign stage = rate_stage(rate_sel_i, mode == MODE_DIRECT);

  prd_prescaler #(.HI_DIV(HI_DIV), .LO_DIV(LO_DIV)) u_pre (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .osc_en_i   (osc_en_i),
    .mode_i     (mode),
    .ref_tick_o (ref_tick)
  );

  prd_chain #(.CHAIN_W(CHAIN_W)) u_chain (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (ref_tick),
    .clr_i  (mode == MODE_CLEAR),
    .cnt_o  (chain_cnt),
    .sec_o  (sec_hit)
  );

  prd_tap_sel #(.CHAIN_W(CHAIN_W), .STG_W(STG_W)) u_tap (
    .cnt_i   (chain_cnt),
    .tick_i  (ref_tick),
    .en_i    (rate_sel_i != 4'd0),
    .stage_i (stage),
    .hit_o   (pf_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pf_q  <= 1'b0;
      sec_q <= 1'b0;
    end else begin
      pf_q  <= pf_hit;
      sec_q <= sec_hit;
    end
  end

  assign pf_set_o   = pf_q;
  assign sec_tick_o = sec_q;

  // R5: rate off gives no pulse
  a_r5_rate_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_sel_i == 4'd0) |=> !pf_set_o);

  // R3: hold codes keep outputs low
  a_r3_hold_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (base_sel_i[2:1] == 2'b11) |=> (!pf_set_o && !sec_tick_o));

  // R4: freeze codes keep outputs low
  a_r4_freeze_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (base_sel_i inside {3'd3, 3'd4, 3'd5}) |=> (!pf_set_o && !sec_tick_o));

  // R9: no strobe, no output in the next cycle
  a_r9_no_strobe_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_en_i |=> (!pf_set_o && !sec_tick_o));

  // R8: second tick is a single-cycle pulse
  a_r8_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_tick_o |=> !sec_tick_o);

endmodule

// File: tb/periodic_rate_divider_test.sv
`timescale 1ns/1ps
module periodic_rate_divider_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_en = 1'b0;
  logic [2:0] base = 3'd2;
  logic [3:0] rate = 4'd0;
  logic       pf_o, sec_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model state
  int    m_cnt = 0;
  int    m_pre = 0;
  logic  exp_pf = 1'b0;
  logic  exp_sec = 1'b0;
  string tag_pf = "R1";
  string tag_sec = "R1";
  int    pf_seen = 0;
  int    sec_seen = 0;

  always #10 clk = ~clk;

  periodic_rate_divider uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .osc_en_i   (osc_en),
    .base_sel_i (base),
    .rate_sel_i (rate),
    .pf_set_o   (pf_o),
    .sec_tick_o (sec_o)
  );

  function automatic int period_log2(input logic [2:0] b, input logic [3:0] r);
    if (r == 4'd1 || r == 4'd2) return (b == 3'd2) ? int'(r) + 6 : int'(r) - 1;
    return int'(r) - 1;
  endfunction

  task automatic model(input logic en, input logic [2:0] b, input logic [3:0] r);
    bit tick;
    int n, p, k;
    exp_pf = 1'b0;
    exp_sec = 1'b0;
    tag_pf = (r == 4'd0) ? "R5" : ((r <= 4'd2) ? "R7" : "R6");
    tag_sec = "R8";
    if (b >= 3'd6) begin
      m_cnt = 0; m_pre = 0; tag_pf = "R3"; tag_sec = "R3";
    end else if (b >= 3'd3) begin
      tag_pf = "R4"; tag_sec = "R4";
    end else begin
      tick = 1'b0;
      if (b == 3'd2) begin
        m_pre = 0;
        tick = en;
      end else if (en) begin
        p = (b == 3'd0) ? 128 : 32;
        if (m_pre >= p - 1) begin tick = 1'b1; m_pre = 0; end
        else m_pre++;
        tag_pf = (r == 4'd0) ? "R5" : "R2";
      end
      if (!en) begin tag_pf = "R9"; tag_sec = "R9"; end
      if (tick) begin
        k = m_cnt + 1;
        if (r != 4'd0) begin
          n = period_log2(b, r);
          p = 1 << n;
          exp_pf = (n == 0) || ((k % p) == (p / 2));
        end
        exp_sec = ((k % 32768) == 0);
        m_cnt = k % 32768;
      end
    end
  endtask

  task automatic check_out();
    checks += 2;
    if (pf_o !== exp_pf) begin
      errors++;
      $display("FAIL %s pf_set_o got %0b expected %0b at %0t", tag_pf, pf_o, exp_pf, $time);
    end
    if (sec_o !== exp_sec) begin
      errors++;
      $display("FAIL %s sec_tick_o got %0b expected %0b at %0t", tag_sec, sec_o, exp_sec, $time);
    end
    if (pf_o === 1'b1) pf_seen++;
    if (sec_o === 1'b1) sec_seen++;
  endtask

  task automatic step(input logic en, input logic [2:0] b, input logic [3:0] r);
    @(negedge clk);
    check_out();
    osc_en = en; base = b; rate = r;
    model(en, b, r);
  endtask

  task automatic expect_count(input string tag, input int got, input int want);
    checks++;
    if (got != want) begin
      errors++;
      $display("FAIL %s count got %0d expected %0d", tag, got, want);
    end
  endtask

  initial begin
    int seed;
    logic [3:0] r;
    int hold_left;
    seed = $urandom(32'd20240601);
    // R1: reset state
    repeat (3) @(negedge clk);
    checks++;
    if (pf_o !== 1'b0 || sec_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 outputs in reset got %0b%0b expected 00", pf_o, sec_o);
    end
    rst_n = 1'b1;

    // R6 R7 R8 R10: direct base, random strobes, random rate changes
    r = 4'd3; hold_left = 0;
    for (int i = 0; i < 48000; i++) begin
      if (hold_left == 0) begin
        r = 4'($urandom_range(0, 15));
        hold_left = $urandom_range(1, 1500);
      end
      hold_left--;
      step(($urandom_range(0, 3) != 0), 3'd2, r);
    end

    // R4: freeze then resume
    for (int i = 0; i < 500; i++) step($urandom_range(0, 1) == 1, 3'd4, 4'd5);
    for (int i = 0; i < 2000; i++) step($urandom_range(0, 3) != 0, 3'd2, 4'd5);

    // R3: hold, then first second tick after exactly 32768 ticks
    for (int i = 0; i < 10; i++) step(1'b1, 3'd7, 4'd15);
    sec_seen = 0;
    for (int i = 0; i < 32770; i++) step(1'b1, 3'd2, 4'd15);
    expect_count("R3", sec_seen, 1);

    // R2 R7: divide-by-128 base, every tick pulses
    for (int i = 0; i < 5; i++) step(1'b1, 3'd6, 4'd1);
    pf_seen = 0;
    for (int i = 0; i < 3000; i++) step(1'b1, 3'd0, 4'd1);
    step(1'b0, 3'd6, 4'd1);
    expect_count("R2", pf_seen, 23);

    // R2 R7: divide-by-32 base, rate 2 -> every second tick
    for (int i = 0; i < 5; i++) step(1'b1, 3'd6, 4'd2);
    pf_seen = 0;
    for (int i = 0; i < 2000; i++) step(1'b1, 3'd1, 4'd2);
    step(1'b0, 3'd6, 4'd2);
    expect_count("R7", pf_seen, 31);

    // R5 R6: divide-by-32 with random strobes and rates
    for (int i = 0; i < 5; i++) step(1'b1, 3'd6, 4'd0);
    for (int i = 0; i < 3000; i++)
      step($urandom_range(0, 3) != 0, 3'd1, (i < 1500) ? 4'd0 : 4'd4);
    step(1'b0, 3'd2, 4'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(64'd200000 * 20);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule